// File: doc/BRIEF.md
# Selective Conflict-Fill Instruction Cache

This block sits between an instruction sequencer and a program-memory port. Instruction fetches and data transfers share that port. Most fetches never touch the cache's storage. A fetch that misses while no data transfer wants the port reads program memory directly in the same cycle, and nothing is written into the cache. Only when a fetch misses in the same cycle that a data transfer claims the shared port does the block stall the sequencer for one cycle. The data transfer takes the port in that cycle. In the following cycle the block reads the instruction, delivers it, and writes it into the cache.

Once a conflicting fetch has been captured this way, every later fetch of that address is served from the cache. The shared port stays free for the data transfer, so the fetch and the transfer finish in the same cycle. A loop whose fetches repeatedly collide with data traffic, such as a filter multiply-accumulate kernel, therefore reaches full speed after its first pass.

Storage is two-way set associative with one replacement bit per set. A synchronous invalidate input clears every entry in one cycle. Hit and allocate strobes report what the cache did in each cycle. Reset is asynchronous and active low, and it is released through a two-stage synchronizer, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `sel_icache`

## Requirements
- R1: While reset is active, and until the first allocation after reset, no fetch hits. During reset `stall_o`, `hit_o` and `alloc_o` are low.
- R2: A valid fetch that misses while `dacc_pend_i` is low completes in the same cycle. In that cycle `pm_req_o`=1, `pm_addr_o` equals the fetch address, `instr_o` equals `pm_rdata_i`, `instr_vld_o`=1, `stall_o`=0 and `alloc_o`=0. No entry is created, so a later conflicting fetch of the same address still misses.
- R3: A valid fetch that misses while `dacc_pend_i` is high sets `stall_o`=1. In that cycle `pm_req_o`=0, `instr_vld_o`=0 and `hit_o`=0.
- R4: The cycle after a conflict stall is a fill cycle, whatever the value of `dacc_pend_i`. In it `pm_req_o`=1, `pm_addr_o` equals the stalled address, `instr_o` equals `pm_rdata_i`, `instr_vld_o`=1, `stall_o`=0 and `alloc_o`=1. The word is stored, and later fetches of that address hit. The sequencer holds the fetch during the stall.
- R5: A valid fetch that hits gives `hit_o`=1, `instr_vld_o`=1, `stall_o`=0 and `pm_req_o`=0, and `instr_o` equals the stored word. This holds with `dacc_pend_i` high or low.
- R6: A loop whose fetches all conflict with data traffic, and whose addresses fit the cache, runs without any stall after its first pass.
- R7: Two addresses that map to the same set, with set index = low address bits, are both kept at once.
- R8: Within a set, victim selection works in this order: first an invalid way (way 0 before way 1), otherwise the way not used most recently. A hit and an allocation both count as a use.
- R9: An `inval_i` pulse makes every entry miss from the next cycle on. A lookup in the same cycle as the pulse still sees the old contents.
- R10: If `inval_i` is high during a fill cycle, the instruction is still delivered, `alloc_o` stays low and no entry is created.
- R11: With `fetch_valid_i` low and no fill in progress, `pm_req_o`, `instr_vld_o`, `hit_o`, `alloc_o` and `stall_o` are all low. `dacc_pend_i` has no effect in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch request from the sequencer |
| fetch_addr_i | input | AW | Fetch address |
| dacc_pend_i | input | 1 | A data transfer claims the shared program-memory port this cycle |
| inval_i | input | 1 | Clear all entries |
| pm_req_o | output | 1 | Instruction read on the shared port |
| pm_addr_o | output | AW | Read address |
| pm_rdata_i | input | IW | Read data, returned in the same cycle |
| instr_o | output | IW | Instruction word |
| instr_vld_o | output | 1 | `instr_o` is valid this cycle |
| stall_o | output | 1 | Sequencer must hold its fetch |
| hit_o | output | 1 | Fetch served from the cache |
| alloc_o | output | 1 | Entry written this cycle |

## Verification
The bench builds the block with 8 entries (four sets) and a 10-bit address. With this geometry, random addresses drawn from a narrow window land on the same set again and again. Three-way contention in a set, evictions and hits right after a replacement therefore occur within a few thousand cycles. The narrow window also gives enough repeats for hits with and without a pending data transfer. Invalidate pulses that fall on fill cycles and on hit cycles then arise together with the directed sequences.

// File: rtl/sic_pkg.sv
`timescale 1ns/1ps
package sic_pkg;
  typedef enum logic {
    SIC_LOOK = 1'b0,
    SIC_FILL = 1'b1
  } sic_state_e;

  localparam int unsigned SIC_WAYS = 2;
endpackage

// File: rtl/sic_way.sv
`timescale 1ns/1ps
module sic_way #(
  parameter int unsigned IW   = 48,
  parameter int unsigned TW   = 20,
  parameter int unsigned SETS = 16,
  localparam int unsigned IXW = $clog2(SETS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inval_i,
  input  logic [IXW-1:0] rd_idx_i,
  input  logic [TW-1:0]  rd_tag_i,
  output logic           hit_o,
  output logic           vld_o,
  output logic [IW-1:0]  rdata_o,
  input  logic           wr_en_i,
  input  logic [IXW-1:0] wr_idx_i,
  input  logic [TW-1:0]  wr_tag_i,
  input  logic [IW-1:0]  wr_data_i
);
  logic [SETS-1:0] vld_q, vld_d;
  logic [TW-1:0]   tag_q  [SETS];
  logic [IW-1:0]   data_q [SETS];

  // valid bits: invalidate overrides a same-cycle write
  always_comb begin
    vld_d = vld_q;
    if (wr_en_i) vld_d[wr_idx_i] = 1'b1;
    if (inval_i) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // storage: no reset, write-enabled
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign vld_o   = vld_q[rd_idx_i];
  assign hit_o   = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rdata_o = data_q[rd_idx_i];
endmodule

// File: rtl/sic_lru.sv
`timescale 1ns/1ps
module sic_lru #(
  parameter int unsigned SETS = 16,
  localparam int unsigned IXW = $clog2(SETS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IXW-1:0] idx_i,
  input  logic           upd_en_i,
  input  logic           upd_way_i,
  output logic           repl_way_o
);
  // each bit names the way to replace next in its set
  logic [SETS-1:0] lru_q, lru_d;

  always_comb begin
    lru_d = lru_q;
    if (upd_en_i) lru_d[idx_i] = ~upd_way_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign repl_way_o = lru_q[idx_i];
endmodule

// File: rtl/sic_ctrl.sv
`timescale 1ns/1ps
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          dacc_pend_i,
  input  logic          inval_i,
  input  logic          any_hit_i,
  output logic          fill_o,
  output logic [AW-1:0] fill_addr_o,
  output logic          stall_o,
  output logic          pm_req_o,
  output logic          instr_vld_o,
  output logic          hit_o,
  output logic          alloc_o
);
  sic_state_e    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          addr_en;

  always_comb begin
    st_d        = SIC_LOOK;
    addr_en     = 1'b0;
    stall_o     = 1'b0;
    pm_req_o    = 1'b0;
    instr_vld_o = 1'b0;
    hit_o       = 1'b0;
    alloc_o     = 1'b0;
    unique case (st_q)
      SIC_LOOK: begin
        if (fetch_valid_i) begin
          if (any_hit_i) begin
            hit_o       = 1'b1;
            instr_vld_o = 1'b1;
          end else if (dacc_pend_i) begin
            stall_o = 1'b1;
            addr_en = 1'b1;
            st_d    = SIC_FILL;
          end else begin
            pm_req_o    = 1'b1;
            instr_vld_o = 1'b1;
          end
        end
      end
      SIC_FILL: begin
        // port belongs to the fill; data side waits this cycle
        pm_req_o    = 1'b1;
        instr_vld_o = 1'b1;
        alloc_o     = !inval_i;
      end
      default: st_d = SIC_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SIC_LOOK;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= fetch_addr_i;
  end

  assign fill_o      = (st_q == SIC_FILL);
  assign fill_addr_o = addr_q;
endmodule

// File: rtl/sel_icache.sv
`timescale 1ns/1ps
module sel_icache
  import sic_pkg::*;
#(
  parameter int unsigned AW      = 24,
  parameter int unsigned IW      = 48,
  parameter int unsigned ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          dacc_pend_i,
  input  logic          inval_i,
  output logic          pm_req_o,
  output logic [AW-1:0] pm_addr_o,
  input  logic [IW-1:0] pm_rdata_i,
  output logic [IW-1:0] instr_o,
  output logic          instr_vld_o,
  output logic          stall_o,
  output logic          hit_o,
  output logic          alloc_o
);
  localparam int unsigned SETS = ENTRIES / SIC_WAYS;
  localparam int unsigned IXW  = $clog2(SETS);
  localparam int unsigned TW   = AW - IXW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          fill;
  logic [AW-1:0] fill_addr;
  logic [AW-1:0] look_addr;
  logic [IXW-1:0] look_idx;
  logic [TW-1:0]  look_tag;
  logic [SIC_WAYS-1:0] way_hit, way_vld;
  logic [IW-1:0]  way_rdata [SIC_WAYS];
  logic           any_hit, hit_way, repl_way, victim;
  logic           lru_upd, lru_way;

  assign look_addr = fill ? fill_addr : fetch_addr_i;
  assign look_idx  = look_addr[IXW-1:0];
  assign look_tag  = look_addr[AW-1:IXW];
  assign pm_addr_o = look_addr;

  for (genvar w = 0; w < SIC_WAYS; w++) begin : g_way
    sic_way #(.IW(IW), .TW(TW), .SETS(SETS)) u_way (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .inval_i   (inval_i),
      .rd_idx_i  (look_idx),
      .rd_tag_i  (look_tag),
      .hit_o     (way_hit[w]),
      .vld_o     (way_vld[w]),
      .rdata_o   (way_rdata[w]),
      .wr_en_i   (alloc_o && (victim == 1'(w))),
      .wr_idx_i  (look_idx),
      .wr_tag_i  (look_tag),
      .wr_data_i (pm_rdata_i)
    );
  end

  assign any_hit = |way_hit;
  assign hit_way = way_hit[1];

  // invalid way first, way 0 before way 1, otherwise the LRU choice
  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = repl_way;
  end

  assign lru_upd = hit_o || alloc_o;
  assign lru_way = hit_o ? hit_way : victim;

  sic_lru #(.SETS(SETS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .idx_i      (look_idx),
    .upd_en_i   (lru_upd),
    .upd_way_i  (lru_way),
    .repl_way_o (repl_way)
  );

  sic_ctrl #(.AW(AW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .dacc_pend_i   (dacc_pend_i),
    .inval_i       (inval_i),
    .any_hit_i     (any_hit),
    .fill_o        (fill),
    .fill_addr_o   (fill_addr),
    .stall_o       (stall_o),
    .pm_req_o      (pm_req_o),
    .instr_vld_o   (instr_vld_o),
    .hit_o         (hit_o),
    .alloc_o       (alloc_o)
  );

  assign instr_o = hit_o ? way_rdata[hit_way] : pm_rdata_i;
endmodule

// File: rtl/sel_icache_chk.sv
`timescale 1ns/1ps
module sel_icache_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid_i,
  input logic [AW-1:0] fetch_addr_i,
  input logic          pm_req_o,
  input logic [AW-1:0] pm_addr_o,
  input logic          instr_vld_o,
  input logic          stall_o,
  input logic          hit_o,
  input logic          alloc_o
);
  // R3: a conflict stall leaves the port to the data side and delivers nothing
  a_r3_stall_frees_port: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (!pm_req_o && !instr_vld_o && !hit_o));

  // R4: a stall is always followed by a fill of the stalled address
  a_r4_fill_follows: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (pm_req_o && instr_vld_o && !stall_o));

  a_r4_fill_addr: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (pm_addr_o == $past(fetch_addr_i)));

  // R2: allocation happens only in the cycle after a conflict stall
  a_r2_alloc_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_o |-> $past(stall_o));

  // R5: a hit never uses the shared port
  a_r5_hit_no_port: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (!pm_req_o && instr_vld_o && !stall_o && !alloc_o));

  // R11: no fetch and no pending fill means a quiet interface
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid_i && !$past(stall_o)) |->
      (!pm_req_o && !instr_vld_o && !hit_o && !stall_o && !alloc_o));
endmodule

bind sel_icache sel_icache_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_sel_icache.sv
`timescale 1ns/1ps
module tb_sel_icache;
  localparam int unsigned AW = 10;
  localparam int unsigned IW = 48;
  localparam int unsigned ENTRIES = 8;
  localparam int unsigned SETS = ENTRIES / 2;
  localparam int unsigned IXW = $clog2(SETS);
  localparam int unsigned TW = AW - IXW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid_i, dacc_pend_i, inval_i;
  logic [AW-1:0] fetch_addr_i;
  logic          pm_req_o, instr_vld_o, stall_o, hit_o, alloc_o;
  logic [AW-1:0] pm_addr_o;
  logic [IW-1:0] pm_rdata_i, instr_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sel_icache #(.AW(AW), .IW(IW), .ENTRIES(ENTRIES)) dut (.*);

  function automatic logic [IW-1:0] memw(input logic [AW-1:0] a);
    return {16'hC0DE ^ 16'(a), 32'(a) * 32'h9E3779B1};
  endfunction

  assign pm_rdata_i = memw(pm_addr_o);

  // reference state
  bit            m_vld [SETS][2];
  logic [TW-1:0] m_tag [SETS][2];
  bit            m_lru [SETS];
  bit            m_fill;
  logic [AW-1:0] m_faddr;

  function automatic void m_clear();
    for (int s = 0; s < SETS; s++) begin
      m_vld[s][0] = 0; m_vld[s][1] = 0;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive after negedge, sample 2 ns before the rising edge
  task automatic step(input bit fv, input logic [AW-1:0] fa, input bit dp,
                      input bit inv, input string req);
    logic [4:0]    e, o;
    logic [AW-1:0] ea;
    logic [IXW-1:0] ix;
    logic [TW-1:0]  tg;
    bit hw, hit_any, vic;
    string lbl;
    fetch_valid_i = fv; fetch_addr_i = fa; dacc_pend_i = dp; inval_i = inv;
    #8;
    ea = m_fill ? m_faddr : fa;
    ix = ea[IXW-1:0];
    tg = ea[AW-1:IXW];
    hit_any = 0; hw = 0;
    for (int w = 0; w < 2; w++)
      if (m_vld[ix][w] && m_tag[ix][w] == tg) begin hit_any = 1; hw = w[0]; end
    vic = !m_vld[ix][0] ? 1'b0 : (!m_vld[ix][1] ? 1'b1 : m_lru[ix]);
    // e = {stall, req, vld, hit, alloc}
    if (m_fill) begin
      e = {1'b0, 1'b1, 1'b1, 1'b0, !inv}; lbl = (inv ? "R10 fill" : "R4 fill");
    end else if (!fv) begin
      e = 5'b0; lbl = "R11 idle";
    end else if (hit_any) begin
      e = 5'b00110; lbl = "R5 hit";
    end else if (dp) begin
      e = 5'b10000; lbl = "R3 stall";
    end else begin
      e = 5'b01100; lbl = "R2 miss";
    end
    o = {stall_o, pm_req_o, instr_vld_o, hit_o, alloc_o};
    chk(o == e, {req, " ", lbl}, "strobes", IW'(o), IW'(e));
    if (e[3]) chk(pm_addr_o == ea, {req, " ", lbl}, "pm_addr", IW'(pm_addr_o), IW'(ea));
    if (e[2]) chk(instr_o == memw(ea), {req, " ", lbl}, "instr", instr_o, memw(ea));
    // model update
    if (m_fill) begin
      if (!inv) begin
        m_vld[ix][vic] = 1; m_tag[ix][vic] = tg; m_lru[ix] = ~vic;
      end
      m_fill = 0;
    end else if (fv && hit_any) begin
      m_lru[ix] = ~hw;
    end else if (fv && dp) begin
      m_fill = 1; m_faddr = fa;
    end
    if (inv) m_clear();
    @(negedge clk);
  endtask

  // fetch; if it stalls, hold the address through the fill cycle
  task automatic fetch(input logic [AW-1:0] a, input bit dp, input string req);
    step(1, a, dp, 0, req);
    if (m_fill) step(1, a, 1'($urandom_range(0, 1)), 0, req);
  endtask

  initial begin
    int stalls;
    void'($urandom(32'h5EED_1CAC));
    rst_n = 0; fetch_valid_i = 0; fetch_addr_i = '0; dacc_pend_i = 0; inval_i = 0;
    m_fill = 0; m_clear();
    for (int s = 0; s < SETS; s++) m_lru[s] = 0;
    repeat (3) @(negedge clk);
    #8;
    chk({stall_o, hit_o, alloc_o} == 3'b000, "R1", "reset outputs",
        IW'({stall_o, hit_o, alloc_o}), '0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) step(0, '0, 1, 0, "R11");

    // R1: empty after reset -> conflicting fetch stalls
    step(1, 10'h005, 1, 0, "R1");
    chk(stall_o == 1'b0 && m_fill, "R1", "first fetch stalls", IW'(m_fill), 1);
    step(1, 10'h005, 0, 0, "R4");

    // R2: plain miss does not allocate
    step(1, 10'h021, 0, 0, "R2");
    step(1, 10'h021, 1, 0, "R2");
    chk(m_fill, "R2", "no allocation on plain miss", IW'(m_fill), 1);
    step(1, 10'h021, 1, 0, "R4");
    // R5: hit with and without data pending
    step(1, 10'h021, 1, 0, "R5");
    step(1, 10'h021, 0, 0, "R5");

    // R7 / R8: set 2
    step(0, '0, 0, 1, "R9");
    fetch(10'h006, 1, "R7");
    fetch(10'h00A, 1, "R7");
    step(1, 10'h006, 0, 0, "R7");
    step(1, 10'h00A, 1, 0, "R7");
    step(1, 10'h006, 1, 0, "R8");
    fetch(10'h00E, 1, "R8");
    step(1, 10'h006, 0, 0, "R8");
    #0 ;
    fetch_valid_i = 1; fetch_addr_i = 10'h00A; dacc_pend_i = 0; inval_i = 0; #8;
    chk(hit_o == 1'b0 && pm_req_o == 1'b1, "R8", "LRU way evicted",
        IW'({hit_o, pm_req_o}), 1);
    @(negedge clk);
    step(1, 10'h00E, 1, 0, "R8");

    // R9: invalidate, then previous hit misses
    step(1, 10'h00E, 0, 1, "R9");
    fetch_valid_i = 1; fetch_addr_i = 10'h00E; #8;
    chk(hit_o == 1'b0, "R9", "miss after invalidate", IW'(hit_o), 0);
    @(negedge clk);

    // R10: invalidate during fill
    step(1, 10'h033, 1, 0, "R10");
    step(1, 10'h033, 0, 1, "R10");
    step(1, 10'h033, 1, 0, "R10");
    chk(m_fill, "R10", "no entry after invalidated fill", IW'(m_fill), 1);
    step(1, 10'h033, 0, 0, "R4");

    // R6: conflicting tight loop
    step(0, '0, 0, 1, "R9");
    for (int i = 0; i < 6; i++) fetch(10'h040 + 10'(i), 1, "R6");
    stalls = 0;
    for (int p = 0; p < 5; p++)
      for (int i = 0; i < 6; i++) begin
        fetch_valid_i = 1; fetch_addr_i = 10'h040 + 10'(i); dacc_pend_i = 1; #8;
        if (stall_o) stalls++;
        #0;
        @(negedge clk);
        if (stalls != 0) fetch(10'h040 + 10'(i), 1, "R6");
      end
    chk(stalls == 0, "R6", "loop stalls after first pass", IW'(stalls), 0);
    // keep model in step: loop fetches were hits, LRU touched
    step(0, '0, 0, 1, "R9");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit fv, dp, inv;
      logic [AW-1:0] a;
      fv  = ($urandom_range(0, 9) != 0);
      dp  = $urandom_range(0, 1);
      inv = ($urandom_range(0, 99) == 0);
      a   = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 31));
      if (m_fill) step(1, m_faddr, dp, inv, "R4");
      else        step(fv, a, dp, inv, "R5");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule